// File: doc/BRIEF.md
# Split/Joined Timer-Counter with Capture

This block is a timer/counter built from two 8-bit halves that software can run apart or chain into a single 16-bit count. A shared programmable prescaler divides the system clock into ticks; two event inputs supply edge-counted external clocks. A two-bit mode field chooses, per half, whether it advances on prescaler ticks or on external events, and whether the halves are joined. Each half compares its count against its own match register and, on a match, wraps to zero and raises a sticky flag. The flags drive two interrupt request lines.

Two capture strobes copy the running count into capture registers. When the halves run apart, each strobe captures its own half. When they are joined, either strobe captures all 16 bits. Configuration, counts, captures and flags sit behind a small single-cycle register port.

Top module: `tmr_split_top`

## Requirements
- R1: After reset every readable register, both counts, both captures, both flags and both interrupt outputs are zero.
- R2: With run (control bit 2) set, the prescaler (address 1, value S) gives one tick every S+1 clock cycles. The first tick comes S+1 cycles after the control write that starts it. With run clear, no count moves.
- R3: On a tick, a count equal to its match register (low at address 2, high at address 3) reloads to zero instead of incrementing.
- R4: The flag register (address 8, bit 0 low, bit 1 high) is sticky. Writing 1 to a bit clears it. If a set and a clear fall in the same cycle, the set wins.
- R5: Mode 0 (control bits 1:0 = 0) runs both halves as independent 8-bit timers on prescaler ticks. Each sets its own flag on a match.
- R6: Mode 1 runs the low half on prescaler ticks. The high half counts rising edges of evtHi, exactly once per edge however long the input stays high.
- R7: Mode 2 joins the halves into a 16-bit timer (high half at address 5, low at address 4) on prescaler ticks. It matches against {high match, low match}, and a match sets only the high flag.
- R8: Mode 3 joins the halves into a 16-bit counter of evtLo rising edges, with the same match and flag rule as R7.
- R9: In modes 0 and 1, capLo copies the low count into address 6 and capHi copies the high count into address 7. The value copied is the one held in the cycle the strobe is seen, before any increment in that cycle.
- R10: In modes 2 and 3, either capture strobe copies the full 16-bit count: low byte to address 6, high byte to address 7.
- R11: A write to the control register (address 0) clears both counts, restarts the prescaler and suppresses ticks in that cycle. Reading address 0 returns mode and run.
- R12: irqLo follows the low flag and irqHi follows the high flag. Reads of addresses 9 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 4 | Read address |
| rdData | output | 8 | Read data, combinational from rdAddr |
| evtLo | input | 1 | External event input for the joined event counter |
| evtHi | input | 1 | External event input for the high half in mode 1 |
| capLo | input | 1 | Low capture strobe |
| capHi | input | 1 | High capture strobe |
| irqLo | output | 1 | Low-half interrupt request |
| irqHi | output | 1 | High-half interrupt request |

## Verification
The hardest case to reach is a flag-clear write landing in the same cycle as a new match. That needs exact phase alignment between the software port and the count. The stimulus makes it happen every cycle by setting the prescaler and both match values to zero, so a match occurs on every clock, and then issuing back-to-back clear writes. A second hard case is the 16-bit wrap in mode 2. The stimulus runs long enough to carry through the low byte and wrap twice, and fires capture strobes at random the whole time, so some of them coincide with carries.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT_TIMERS  = 2'd0,
    MODE_TIMER_EVENTS  = 2'd1,
    MODE_JOINED_TIMER  = 2'd2,
    MODE_JOINED_EVENTS = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic       tickLo;
    logic       tickHi;
    logic       joined;
    logic       takeLo;
    logic       takeHi;
    logic       clrCnt;
    logic [1:0] flagClr;
  } tmrStrobe_t;

  localparam int REG_CTRL   = 0;
  localparam int REG_PRESC  = 1;
  localparam int REG_MATLO  = 2;
  localparam int REG_MATHI  = 3;
  localparam int REG_CNTLO  = 4;
  localparam int REG_CNTHI  = 5;
  localparam int REG_CAPLO  = 6;
  localparam int REG_CAPHI  = 7;
  localparam int REG_FLAGS  = 8;

  localparam int CTRL_RUN_BIT = 2;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PS_W   = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [HALF_W-1:0] wrData,
  input  logic              evtLo,
  input  logic              evtHi,
  input  logic              capLo,
  input  logic              capHi,
  output tmrStrobe_t        stb,
  output logic [HALF_W-1:0] matchLo,
  output logic [HALF_W-1:0] matchHi,
  output logic [HALF_W-1:0] prescRd,
  output logic [1:0]        modeRd,
  output logic              runRd
);

  tmrMode_e        modeQ;
  logic            runQ;
  logic [PS_W-1:0] prescQ;
  logic [PS_W-1:0] psCnt;
  logic            evtLoQ, evtHiQ;
  logic            evtLoRise, evtHiRise;
  logic            preTick;
  logic            ctrlWr;
  logic            flagWr;
  logic            go;

  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(REG_CTRL));
  assign flagWr = wrEn && (wrAddr == ADDR_W'(REG_FLAGS));

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_SPLIT_TIMERS;
      runQ    <= 1'b0;
      prescQ  <= '0;
      matchLo <= '0;
      matchHi <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(REG_CTRL)) begin
        modeQ <= tmrMode_e'(wrData[1:0]);
        runQ  <= wrData[CTRL_RUN_BIT];
      end
      if (wrAddr == ADDR_W'(REG_PRESC)) prescQ  <= PS_W'(wrData);
      if (wrAddr == ADDR_W'(REG_MATLO)) matchLo <= wrData;
      if (wrAddr == ADDR_W'(REG_MATHI)) matchHi <= wrData;
    end
  end

  // prescaler: down-counter reloaded from its setting
  assign preTick = runQ && (psCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            psCnt <= '0;
    else if (!runQ || ctrlWr || preTick)  psCnt <= prescQ;
    else                                  psCnt <= psCnt - 1'b1;
  end

  // event edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtLoQ <= 1'b0;
      evtHiQ <= 1'b0;
    end else begin
      evtLoQ <= evtLo;
      evtHiQ <= evtHi;
    end
  end

  assign evtLoRise = evtLo && !evtLoQ;
  assign evtHiRise = evtHi && !evtHiQ;
  assign go        = runQ && !ctrlWr;

  // mode decode into strobes
  always_comb begin
    stb        = '0;
    stb.joined = modeQ[1];
    unique case (modeQ)
      MODE_SPLIT_TIMERS: begin
        stb.tickLo = go && preTick;
        stb.tickHi = go && preTick;
      end
      MODE_TIMER_EVENTS: begin
        stb.tickLo = go && preTick;
        stb.tickHi = go && evtHiRise;
      end
      MODE_JOINED_TIMER:  stb.tickLo = go && preTick;
      MODE_JOINED_EVENTS: stb.tickLo = go && evtLoRise;
      default: ;
    endcase
    stb.takeLo  = stb.joined ? (capLo || capHi) : capLo;
    stb.takeHi  = stb.joined ? (capLo || capHi) : capHi;
    stb.clrCnt  = ctrlWr;
    stb.flagClr = flagWr ? wrData[1:0] : 2'b00;
  end

  assign prescRd = HALF_W'(prescQ);
  assign modeRd  = modeQ;
  assign runRd   = runQ;

  AST_PS_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    preTick |=> psCnt == $past(prescQ)); // R2

  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    evtHiRise |=> !evtHiRise); // R6

  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !stb.tickLo && !stb.tickHi); // R2

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        stb,
  input  logic [HALF_W-1:0] matchLo,
  input  logic [HALF_W-1:0] matchHi,
  output logic [HALF_W-1:0] cntLo,
  output logic [HALF_W-1:0] cntHi,
  output logic [HALF_W-1:0] capLoQ,
  output logic [HALF_W-1:0] capHiQ,
  output logic              flagLo,
  output logic              flagHi
);

  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] cntAll;
  logic [FULL_W-1:0] matchAll;
  logic [HALF_W-1:0] nxtLo, nxtHi;
  logic              setLo, setHi;

  assign cntAll   = {cntHi, cntLo};
  assign matchAll = {matchHi, matchLo};

  always_comb begin
    nxtLo = cntLo;
    nxtHi = cntHi;
    setLo = 1'b0;
    setHi = 1'b0;
    if (stb.clrCnt) begin
      nxtLo = '0;
      nxtHi = '0;
    end else if (stb.joined) begin
      if (stb.tickLo) begin
        if (cntAll == matchAll) begin
          {nxtHi, nxtLo} = '0;
          setHi          = 1'b1;
        end else begin
          {nxtHi, nxtLo} = cntAll + 1'b1;
        end
      end
    end else begin
      if (stb.tickLo) begin
        if (cntLo == matchLo) begin
          nxtLo = '0;
          setLo = 1'b1;
        end else begin
          nxtLo = cntLo + 1'b1;
        end
      end
      if (stb.tickHi) begin
        if (cntHi == matchHi) begin
          nxtHi = '0;
          setHi = 1'b1;
        end else begin
          nxtHi = cntHi + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo  <= '0;
      cntHi  <= '0;
      capLoQ <= '0;
      capHiQ <= '0;
      flagLo <= 1'b0;
      flagHi <= 1'b0;
    end else begin
      cntLo  <= nxtLo;
      cntHi  <= nxtHi;
      if (stb.takeLo) capLoQ <= cntLo;
      if (stb.takeHi) capHiQ <= cntHi;
      flagLo <= setLo || (flagLo && !stb.flagClr[0]);
      flagHi <= setHi || (flagHi && !stb.flagClr[1]);
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    flagLo && !stb.flagClr[0] |=> flagLo); // R4

  AST_CAP_PRE_INC: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeLo |=> capLoQ == $past(cntLo)); // R9

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tickLo && !stb.tickHi && !stb.clrCnt |=> $stable(cntLo) && $stable(cntHi)); // R2

  AST_JOINED_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    stb.joined && stb.tickLo && !stb.clrCnt && (cntAll == matchAll)
      |=> (cntLo == '0) && (cntHi == '0) && flagHi); // R7

endmodule

// File: rtl/tmr_split_top.sv
module tmr_split_top
  import tmr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PS_W   = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [HALF_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [HALF_W-1:0] rdData,
  input  logic              evtLo,
  input  logic              evtHi,
  input  logic              capLo,
  input  logic              capHi,
  output logic              irqLo,
  output logic              irqHi
);

  tmrStrobe_t        stb;
  logic [HALF_W-1:0] matchLo, matchHi, prescRd;
  logic [HALF_W-1:0] cntLo, cntHi, capLoQ, capHiQ;
  logic [1:0]        modeRd;
  logic              runRd;
  logic              flagLo, flagHi;

  tmr_ctrl #(.HALF_W(HALF_W), .PS_W(PS_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtLo(evtLo), .evtHi(evtHi), .capLo(capLo), .capHi(capHi),
    .stb(stb), .matchLo(matchLo), .matchHi(matchHi), .prescRd(prescRd),
    .modeRd(modeRd), .runRd(runRd)
  );

  tmr_datapath #(.HALF_W(HALF_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .matchLo(matchLo), .matchHi(matchHi),
    .cntLo(cntLo), .cntHi(cntHi), .capLoQ(capLoQ), .capHiQ(capHiQ),
    .flagLo(flagLo), .flagHi(flagHi)
  );

  always_comb begin
    rdData = '0;
    if      (rdAddr == ADDR_W'(REG_CTRL))  rdData = HALF_W'({runRd, modeRd});
    else if (rdAddr == ADDR_W'(REG_PRESC)) rdData = prescRd;
    else if (rdAddr == ADDR_W'(REG_MATLO)) rdData = matchLo;
    else if (rdAddr == ADDR_W'(REG_MATHI)) rdData = matchHi;
    else if (rdAddr == ADDR_W'(REG_CNTLO)) rdData = cntLo;
    else if (rdAddr == ADDR_W'(REG_CNTHI)) rdData = cntHi;
    else if (rdAddr == ADDR_W'(REG_CAPLO)) rdData = capLoQ;
    else if (rdAddr == ADDR_W'(REG_CAPHI)) rdData = capHiQ;
    else if (rdAddr == ADDR_W'(REG_FLAGS)) rdData = HALF_W'({flagHi, flagLo});
  end

  assign irqLo = flagLo;
  assign irqHi = flagHi;

endmodule

// File: tb/tmr_split_top_test.sv
`timescale 1ns/1ps
module tmr_split_top_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       evtLo = 1'b0, evtHi = 1'b0, capLo = 1'b0, capHi = 1'b0;
  logic       irqLo, irqHi;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  tmr_split_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtLo(evtLo), .evtHi(evtHi),
    .capLo(capLo), .capHi(capHi), .irqLo(irqLo), .irqHi(irqHi)
  );

  // behavioural reference model
  int mMode = 0, mRun = 0, mPresc = 0, mPs = 0, mMLo = 0, mMHi = 0;
  int mCLo = 0, mCHi = 0, mCapL = 0, mCapH = 0, mFL = 0, mFH = 0;
  int mELoQ = 0, mEHiQ = 0;

  always @(posedge clk or negedge rstN) begin
    int ctrlW, go, pt, rL, rH, tL, tH, joined, all, sL, sH, clr;
    if (!rstN) begin
      mMode = 0; mRun = 0; mPresc = 0; mPs = 0; mMLo = 0; mMHi = 0;
      mCLo = 0; mCHi = 0; mCapL = 0; mCapH = 0; mFL = 0; mFH = 0;
      mELoQ = 0; mEHiQ = 0;
    end else begin
      ctrlW  = (wrEn && wrAddr == 0) ? 1 : 0;
      go     = (mRun != 0 && ctrlW == 0) ? 1 : 0;
      pt     = (mRun != 0 && mPs == 0) ? 1 : 0;
      rL     = (evtLo && mELoQ == 0) ? 1 : 0;
      rH     = (evtHi && mEHiQ == 0) ? 1 : 0;
      joined = (mMode >= 2) ? 1 : 0;
      case (mMode)
        0: begin tL = pt; tH = pt; end
        1: begin tL = pt; tH = rH; end
        2: begin tL = pt; tH = 0;  end
        default: begin tL = rL; tH = 0; end
      endcase
      tL = tL & go; tH = tH & go;
      // captures take the pre-update count
      if (joined != 0) begin
        if (capLo || capHi) begin mCapL = mCLo; mCapH = mCHi; end
      end else begin
        if (capLo) mCapL = mCLo;
        if (capHi) mCapH = mCHi;
      end
      sL = 0; sH = 0;
      if (ctrlW != 0) begin
        mCLo = 0; mCHi = 0;
      end else if (joined != 0) begin
        all = mCHi * 256 + mCLo;
        if (tL != 0) begin
          if (all == mMHi * 256 + mMLo) begin all = 0; sH = 1; end
          else all = (all + 1) % 65536;
        end
        mCHi = all / 256; mCLo = all % 256;
      end else begin
        if (tL != 0) begin
          if (mCLo == mMLo) begin mCLo = 0; sL = 1; end else mCLo = (mCLo + 1) % 256;
        end
        if (tH != 0) begin
          if (mCHi == mMHi) begin mCHi = 0; sH = 1; end else mCHi = (mCHi + 1) % 256;
        end
      end
      clr = (wrEn && wrAddr == 8) ? int'(wrData) : 0;
      mFL = (sL != 0 || (mFL != 0 && (clr & 1) == 0)) ? 1 : 0;
      mFH = (sH != 0 || (mFH != 0 && (clr & 2) == 0)) ? 1 : 0;
      if (mRun == 0 || ctrlW != 0 || mPs == 0) mPs = mPresc; else mPs = mPs - 1;
      mELoQ = evtLo ? 1 : 0;
      mEHiQ = evtHi ? 1 : 0;
      if (wrEn) begin
        case (wrAddr)
          4'd0: begin mMode = int'(wrData) & 3; mRun = (int'(wrData) >> 2) & 1; end
          4'd1: mPresc = int'(wrData);
          4'd2: mMLo = int'(wrData);
          4'd3: mMHi = int'(wrData);
          default: ;
        endcase
      end
    end
  end

  function automatic int expRead(input int a);
    case (a)
      0: return mMode + 4 * mRun;
      1: return mPresc;
      2: return mMLo;
      3: return mMHi;
      4: return mCLo;
      5: return mCHi;
      6: return mCapL;
      7: return mCapH;
      8: return mFL + 2 * mFH;
      default: return 0;
    endcase
  endfunction

  function automatic string tagFor(input int a);
    if (cycles < 4) return "R1";
    case (a)
      0: return "R11";
      1: return "R2";
      2, 3: return "R3";
      4, 5: case (mMode) 0: return "R5"; 1: return "R6"; 2: return "R7"; default: return "R8"; endcase
      6: return "R9";
      7: return (mMode >= 2) ? "R10" : "R9";
      8: return "R4";
      default: return "R12";
    endcase
  endfunction

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      cycles++;
      nChecks++;
      if (int'(rdData) != expRead(int'(rdAddr))) begin
        nFails++;
        $display("FAIL %s addr %0d: got %0h expected %0h at cycle %0d",
                 tagFor(int'(rdAddr)), rdAddr, rdData, expRead(int'(rdAddr)), cycles);
      end
      nChecks++;
      if (irqLo != (mFL != 0) || irqHi != (mFH != 0)) begin
        nFails++;
        $display("FAIL R12 irq: got %0b%0b expected %0b%0b at cycle %0d",
                 irqHi, irqLo, mFH != 0, mFL != 0, cycles);
      end
      rdAddr = (rdAddr == 4'd9) ? 4'd0 : rdAddr + 4'd1;
    end
  end

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic drive(input int n, input int evtMask);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evtLo = (evtMask & 1) ? ($urandom % 2 == 0) : 1'b0;
      evtHi = (evtMask & 2) ? ($urandom % 3 != 0) : 1'b0;
      capLo = ($urandom % 5 == 0);
      capHi = ($urandom % 5 == 0);
    end
    @(negedge clk);
    evtLo = 1'b0; evtHi = 1'b0; capLo = 1'b0; capHi = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);           // R1 reset values checked here
    rstN = 1'b1;
    repeat (12) @(negedge clk);
    // R5 R3: split prescaled timers
    writeReg(4'd1, 8'd2);
    writeReg(4'd2, 8'd5);
    writeReg(4'd3, 8'd3);
    writeReg(4'd0, 8'h04);
    drive(60, 3);
    writeReg(4'd8, 8'h03);               // R4 clear
    drive(20, 3);
    // R2: halted, counts must hold
    writeReg(4'd0, 8'h00);
    drive(20, 3);
    // R6: high half counts evtHi edges
    writeReg(4'd0, 8'h05);
    drive(120, 2);
    // R7 R10: joined 16-bit timer, wraps past low byte
    writeReg(4'd8, 8'h03);
    writeReg(4'd1, 8'd0);
    writeReg(4'd2, 8'h20);
    writeReg(4'd3, 8'h01);
    writeReg(4'd0, 8'h06);
    drive(700, 3);
    // R8: joined event counter
    writeReg(4'd8, 8'h03);
    writeReg(4'd2, 8'd7);
    writeReg(4'd3, 8'd0);
    writeReg(4'd0, 8'h07);
    drive(200, 3);
    // R4: clear coinciding with set every cycle
    writeReg(4'd2, 8'd0);
    writeReg(4'd0, 8'h04);
    for (int k = 0; k < 12; k++) writeReg(4'd8, 8'h03);
    writeReg(4'd0, 8'h00);
    writeReg(4'd8, 8'h03);
    drive(20, 0);
    // R11: control write mid-count
    writeReg(4'd1, 8'd1);
    writeReg(4'd2, 8'd200);
    writeReg(4'd0, 8'h04);
    drive(30, 0);
    writeReg(4'd0, 8'h04);
    drive(30, 0);
    @(posedge clk); #3;
    finishRun();
  end

endmodule